// File: doc/BRIEF.md
# Address-Translation Control Register Legalizer

This block keeps the three address-translation control registers of a hart that can run a hypervisor: the supervisor register, the virtual-supervisor register and the guest-stage register. Each register holds a translation mode, an address-space identifier and a root page-table page number. Address decode and privilege checks happen outside the block. They present a write strobe, a 2-bit register select and the write data. On each write the block decides whether the value is legal and worth storing. It either commits the new value in full or keeps the old one, so a read always returns a legal value.

The requested mode is looked up in a supported-mode bitmask, where bit `mode` of the mask allows that mode. A write commits only when its mode is allowed and it changes at least one bit inside the mode, identifier and page-number fields. Every committed write produces a one-cycle TLB flush request, including a write that selects Bare mode. The field layout follows the current XLEN, which is chosen at runtime by a select input. A strap tells the block whether translation hardware exists. When it is low, writes to the supervisor register are dropped.

Top module: `atp_csr_unit`

## Requirements
- R1: A synchronous active-high reset clears all three registers to zero (Bare mode), and `tlb_flush` is low in the first cycle after reset.
- R2: In the 64-bit layout (mode in bits 63:60, identifier in 59:44, page number in 43:0), a write with a supported mode that changes some field stores `csr_wdata`. After the clock edge `csr_rdata` returns the stored value for that select.
- R3: A write whose mode is not set in the supported-mode mask leaves every register unchanged and raises no flush. With the default 64-bit mask, only codes 0, 8, 9 and 10 are supported.
- R4: A write whose value equals the current register contents in all field bits stores nothing and raises no flush.
- R5: Each committed write sets `tlb_flush` high for exactly the one cycle that follows the write's clock edge. A committed write of mode 0 (Bare) also sets it. `tlb_flush` is never high without a write in the previous cycle.
- R6: With `rv32` high, the 32-bit layout applies: the mode is bit 31, the identifier is bits 30:22 and the page number is bits 21:0. Only bits 31:0 are compared and stored, and the stored value has bits 63:32 cleared.
- R7: With `mmu_present` low, writes to select 0 (supervisor) are ignored, while selects 1 and 2 still follow the normal rule.
- R8: Select 1 (virtual supervisor) and select 2 (guest stage) follow the same legalization rule as select 0. Select 3 names no register: writes to it are ignored and it reads as zero.
- R9: A write changes only the register named by `csr_sel`. The other two registers keep their contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_we | input | 1 | Write strobe for the selected register |
| csr_sel | input | 2 | Register select: 0 supervisor, 1 virtual supervisor, 2 guest stage, 3 none |
| csr_wdata | input | 64 | Requested new register value |
| rv32 | input | 1 | High selects the 32-bit field layout |
| mmu_present | input | 1 | Strap: translation hardware exists |
| csr_rdata | output | 64 | Current contents of the selected register (combinational) |
| tlb_flush | output | 1 | Registered one-cycle TLB flush request |

## Verification
A wrong decision in the commit logic shows up at the ports one edge after the write. `csr_rdata` then either holds a value that should have been rejected or still holds the old value after a legal change. `tlb_flush` in that same cycle disagrees with the model. Writing to the wrong register only becomes visible when that register is selected again. The bench therefore selects every register with writes disabled at regular points, and compares read data and the flush bit against a behavioural model on every clock.

// File: rtl/atp_pkg.sv
package atp_pkg;
  localparam int XLEN  = 64;
  localparam int NREGS = 3;
  localparam int SELW  = 2;

  typedef logic [XLEN-1:0] atp_word_t;

  typedef enum logic [SELW-1:0] {
    SEL_SUP   = 2'd0,
    SEL_VSUP  = 2'd1,
    SEL_GUEST = 2'd2,
    SEL_NONE  = 2'd3
  } atp_sel_e;

  // Field masks of the two layouts: every bit of the 32-bit layout lies in
  // 31:0, and the 64-bit layout covers the whole word.
  localparam atp_word_t FMASK32 = {32'h0, 32'hFFFF_FFFF};
  localparam atp_word_t FMASK64 = '1;
endpackage

// File: rtl/atp_layout.sv
module atp_layout
  import atp_pkg::*;
#(
  parameter logic [1:0]  MODES_RV32 = 2'b11,
  parameter logic [15:0] MODES_RV64 = 16'h0701
) (
  input  logic      rv32,
  input  atp_word_t wdata,
  output logic      mode_ok,
  output atp_word_t fmask
);
  logic [3:0] mode64;
  logic       mode32;

  assign mode64 = wdata[XLEN-1 -: 4];
  assign mode32 = wdata[31];

  always_comb begin
    if (rv32) begin
      mode_ok = MODES_RV32[mode32];
      fmask   = FMASK32;
    end else begin
      mode_ok = MODES_RV64[mode64];
      fmask   = FMASK64;
    end
  end
endmodule

// File: rtl/atp_legalize.sv
module atp_legalize
  import atp_pkg::*;
(
  input  logic      we,
  input  logic      target_ok,
  input  logic      mode_ok,
  input  atp_word_t fmask,
  input  atp_word_t old_val,
  input  atp_word_t wdata,
  output logic      commit,
  output atp_word_t new_val
);
  logic changed;

  assign changed = |((wdata ^ old_val) & fmask);
  assign commit  = we && target_ok && mode_ok && changed;
  assign new_val = wdata & fmask;
endmodule

// File: rtl/atp_bank.sv
module atp_bank
  import atp_pkg::*;
#(
  parameter int N = NREGS
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [N-1:0]          wr_vec,
  input  atp_word_t             wval,
  output logic [N-1:0][XLEN-1:0] regs
);
  for (genvar g = 0; g < N; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)            regs[g] <= '0;
      else if (wr_vec[g]) regs[g] <= wval;
    end
  end
endmodule

// File: rtl/atp_csr_unit.sv
module atp_csr_unit
  import atp_pkg::*;
#(
  parameter logic [1:0]  MODES_RV32 = 2'b11,
  parameter logic [15:0] MODES_RV64 = 16'h0701
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        csr_we,
  input  logic [1:0]  csr_sel,
  input  logic [63:0] csr_wdata,
  input  logic        rv32,
  input  logic        mmu_present,
  output logic [63:0] csr_rdata,
  output logic        tlb_flush
);
  logic [NREGS-1:0][XLEN-1:0] regs_w;
  logic [NREGS-1:0]           wr_vec;
  atp_word_t old_val, new_val, fmask;
  logic      mode_ok, target_ok, commit;

  always_comb begin
    case (csr_sel)
      SEL_SUP:   old_val = regs_w[0];
      SEL_VSUP:  old_val = regs_w[1];
      SEL_GUEST: old_val = regs_w[2];
      default:   old_val = '0;
    endcase
  end

  assign csr_rdata = old_val;
  assign target_ok = (csr_sel != SEL_NONE) && !((csr_sel == SEL_SUP) && !mmu_present);

  atp_layout #(.MODES_RV32(MODES_RV32), .MODES_RV64(MODES_RV64)) u_layout (
    .rv32    (rv32),
    .wdata   (csr_wdata),
    .mode_ok (mode_ok),
    .fmask   (fmask)
  );

  atp_legalize u_legal (
    .we        (csr_we),
    .target_ok (target_ok),
    .mode_ok   (mode_ok),
    .fmask     (fmask),
    .old_val   (old_val),
    .wdata     (csr_wdata),
    .commit    (commit),
    .new_val   (new_val)
  );

  for (genvar g = 0; g < NREGS; g++) begin : g_wr
    assign wr_vec[g] = commit && (csr_sel == SELW'(g));
  end

  atp_bank #(.N(NREGS)) u_bank (
    .clk    (clk),
    .rst    (rst),
    .wr_vec (wr_vec),
    .wval   (new_val),
    .regs   (regs_w)
  );

  always_ff @(posedge clk) begin
    if (rst) tlb_flush <= 1'b0;
    else     tlb_flush <= commit;
  end
endmodule

// File: rtl/atp_csr_chk.sv
module atp_csr_chk #(
  parameter logic [15:0] MODES_RV64 = 16'h0701
) (
  input logic        clk,
  input logic        rst,
  input logic        csr_we,
  input logic [1:0]  csr_sel,
  input logic [63:0] csr_wdata,
  input logic        rv32,
  input logic        mmu_present,
  input logic        tlb_flush,
  input logic [63:0] sup_q,
  input logic [63:0] vsup_q,
  input logic [63:0] guest_q
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (sup_q == 64'd0 && vsup_q == 64'd0 && guest_q == 64'd0 && !tlb_flush));

  // R5
  flush_needs_write_chk: assert property (@(posedge clk) disable iff (rst)
    tlb_flush |-> $past(csr_we));

  // R5
  flush_means_change_chk: assert property (@(posedge clk) disable iff (rst)
    tlb_flush |-> (sup_q != $past(sup_q) || vsup_q != $past(vsup_q) || guest_q != $past(guest_q)));

  // R3
  bad_mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (csr_we && !rv32 && !MODES_RV64[csr_wdata[63:60]])
      |=> ($stable(sup_q) && $stable(vsup_q) && $stable(guest_q) && !tlb_flush));

  // R7
  mmu_off_chk: assert property (@(posedge clk) disable iff (rst)
    (csr_we && csr_sel == 2'd0 && !mmu_present) |=> ($stable(sup_q) && !tlb_flush));

  // R8
  sel_none_chk: assert property (@(posedge clk) disable iff (rst)
    (csr_we && csr_sel == 2'd3)
      |=> ($stable(sup_q) && $stable(vsup_q) && $stable(guest_q) && !tlb_flush));

  // R9
  others_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (csr_we && csr_sel == 2'd1) |=> ($stable(sup_q) && $stable(guest_q)));

  // R6
  rv32_upper_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (tlb_flush && $past(rv32) && $past(csr_sel) == 2'd0) |-> (sup_q[63:32] == 32'd0));
endmodule

bind atp_csr_unit atp_csr_chk #(.MODES_RV64(MODES_RV64)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .csr_we      (csr_we),
  .csr_sel     (csr_sel),
  .csr_wdata   (csr_wdata),
  .rv32        (rv32),
  .mmu_present (mmu_present),
  .tlb_flush   (tlb_flush),
  .sup_q       (regs_w[0]),
  .vsup_q      (regs_w[1]),
  .guest_q     (regs_w[2])
);

// File: tb/atp_csr_unit_tb.sv
module atp_csr_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        csr_we = 1'b0;
  logic [1:0]  csr_sel = 2'd0;
  logic [63:0] csr_wdata = 64'd0;
  logic        rv32 = 1'b0;
  logic        mmu_present = 1'b1;
  logic [63:0] csr_rdata;
  logic        tlb_flush;

  always #2.5 clk = ~clk;

  atp_csr_unit u_dut (
    .clk(clk), .rst(rst), .csr_we(csr_we), .csr_sel(csr_sel),
    .csr_wdata(csr_wdata), .rv32(rv32), .mmu_present(mmu_present),
    .csr_rdata(csr_rdata), .tlb_flush(tlb_flush)
  );

  // behavioural reference
  logic [63:0] m_reg [3];
  logic        m_flush;
  int vectors = 0;
  int errors  = 0;
  bit done    = 0;

  function automatic bit m_mode_ok(bit r32, logic [63:0] d);
    if (r32) return 1'b1;
    return (d[63:60] == 4'd0 || d[63:60] == 4'd8 || d[63:60] == 4'd9 || d[63:60] == 4'd10);
  endfunction

  task automatic step(input bit we, input int sel, input logic [63:0] d,
                      input bit r32, input bit mmu, input string tag);
    logic [63:0] fm, old, exp_rd;
    bit commit;
    @(negedge clk);
    csr_we = we; csr_sel = sel[1:0]; csr_wdata = d; rv32 = r32; mmu_present = mmu;
    @(posedge clk);
    fm  = r32 ? 64'h0000_0000_FFFF_FFFF : 64'hFFFF_FFFF_FFFF_FFFF;
    old = (sel < 3) ? m_reg[sel] : 64'd0;
    commit = we && sel < 3 && !(sel == 0 && !mmu) && m_mode_ok(r32, d) && (((d ^ old) & fm) != 0);
    if (commit) m_reg[sel] = d & fm;
    m_flush = commit;
    @(negedge clk);
    exp_rd = (sel < 3) ? m_reg[sel] : 64'd0;
    vectors++;
    if (csr_rdata !== exp_rd || tlb_flush !== m_flush) begin
      errors++;
      $display("FAIL %s: sel=%0d rdata=%h flush=%b expected rdata=%h flush=%b",
               tag, sel, csr_rdata, tlb_flush, exp_rd, m_flush);
    end
    csr_we = 1'b0;
  endtask

  task automatic peek_all(input string tag);
    for (int s = 0; s < 4; s++) step(0, s, 64'd0, 0, 1, tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run hung, actual=running expected=finished");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 3; i++) m_reg[i] = 64'd0;
    m_flush = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    // R1 reset state
    peek_all("R1");
    // R2 legal Sv39 write
    step(1, 0, 64'h8000_1234_0000_5678, 0, 1, "R2");
    step(0, 0, 64'd0, 0, 1, "R5");
    // R3 unsupported modes (5, 1, 15)
    step(1, 0, 64'h5000_0000_0000_0001, 0, 1, "R3");
    step(1, 0, 64'h1000_0000_0000_0001, 0, 1, "R3");
    step(1, 1, 64'hF123_4567_89AB_CDEF, 0, 1, "R3");
    // R4 rewrite of identical value
    step(1, 0, 64'h8000_1234_0000_5678, 0, 1, "R4");
    // R5 Bare write still flushes, back-to-back commits
    step(1, 0, 64'h0000_0000_0000_0000, 0, 1, "R5");
    step(1, 0, 64'h9000_0000_0000_0010, 0, 1, "R5");
    step(1, 0, 64'h9000_0000_0000_0011, 0, 1, "R5");
    // R8 other registers and select 3
    step(1, 1, 64'h9ABC_D000_0000_1000, 0, 1, "R8");
    step(1, 2, 64'hA001_0000_0000_2000, 0, 1, "R8");
    step(1, 3, 64'h8000_0000_0000_0003, 0, 1, "R8");
    // R9 neighbours unchanged
    peek_all("R9");
    // R7 strap low
    step(1, 0, 64'h8000_0000_0000_0077, 0, 0, "R7");
    step(1, 1, 64'h8000_0000_0000_0078, 0, 0, "R7");
    peek_all("R7");
    // R6 32-bit layout
    step(1, 0, 64'hFFFF_0000_8040_0123, 1, 1, "R6");
    step(1, 0, 64'h1234_5678_8040_0123, 1, 1, "R6");
    step(1, 2, 64'hDEAD_BEEF_0000_0000, 1, 1, "R6");
    step(1, 2, 64'hAAAA_AAAA_7FFF_FFFF, 1, 1, "R6");
    peek_all("R6");
    // mixed sweep
    for (int k = 0; k < 300; k++) begin
      logic [63:0] d;
      logic [3:0]  modes [6] = '{4'd0, 4'd8, 4'd9, 4'd10, 4'd1, 4'd12};
      d = {$urandom, $urandom};
      d[63:60] = modes[$urandom_range(0, 5)];
      if ($urandom_range(0, 3) == 0) d[43:0] = 44'd0;
      step($urandom_range(0, 3) != 0, $urandom_range(0, 3), d,
           $urandom_range(0, 4) == 0, $urandom_range(0, 5) != 0, "R2");
    end
    peek_all("R9");
    finish_run();
  end
endmodule